// File: doc/BRIEF.md
# Vectored priority interrupt controller

This block sits beside a small single-issue CPU and decides, each cycle, whether an interrupt is taken and at which program address the handler entry lies. It watches a parameterised number of request lines. Each line is fixed at build time as one of two kinds. A latched line keeps a pending flag that is set by a rising edge on the line. A level line requests service only while its input is high and has no memory.

A request is serviced only when its per-source enable and a global enable are both set. Among the serviceable requests the lowest index wins. The controller raises a take strobe with the vector address in the same cycle, and it clears the global enable and the winning latched flag at the next edge. Software can set or clear the global enable and can clear flags by writing ones. A return-from-interrupt strobe sets the global enable again. After that strobe, no interrupt is accepted until the CPU reports that one main-program instruction has retired. A select input moves the vector table to an alternate base. Slot 0 of the table is reserved for reset, so source k uses slot k+1.

Top module: `irq_vec_ctrl`

## Requirements
- R1: An interrupt is taken (irq_take_o=1) only in a cycle where the global enable is 1 and the winning source has src_en_i set and is pending.
- R2: When several sources are serviceable, the lowest index is taken. irq_vec_o = base + 2*(k+1) for source k, with slot 0 left for reset.
- R3: The cycle after a take, gie_o is 0. The cycle after reti_i, gie_o is 1, unless a take or gie_clr_i occurs in that same cycle.
- R4: A latched source sets its flag on a rising edge of src_i[k]. The flag clears at the edge after it is taken, or after flag_clr_i[k]=1. An edge that arrives in the same cycle as a clear still leaves the flag set.
- R5: A latched flag set while the source or global enable is 0 stays pending and is taken once both enables are 1.
- R6: A level source is pending exactly while src_i[k]=1. A pulse that ends before it is enabled leaves no trace in pend_o and causes no take.
- R7: From the cycle of reti_i until a later cycle that has retire_i=1, irq_take_o stays 0. In the cycle after that retire, a take is possible again.
- R8: In a cycle with gie_clr_i=1 no interrupt is taken. gie_clr_i wins over gie_set_i, and gie_o is 0 afterwards.
- R9: vec_sel_i=1 selects base BASE_ALT (default 0x1C00) and vec_sel_i=0 selects BASE_MAIN (default 0x0000) for irq_vec_o in the same cycle.
- R10: gie_set_i inside a handler (no reti) sets gie_o again, and any enabled pending source can then be taken, which gives nesting.
- R11: After reset, gie_o=0, pend_o=0, irq_take_o=0, and no post-return hold is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Raw interrupt conditions |
| src_en_i | input | N_SRC | Per-source enables |
| flag_clr_i | input | N_SRC | Write-one-to-clear strobes for latched flags |
| gie_set_i | input | 1 | Set global enable |
| gie_clr_i | input | 1 | Clear global enable, effective this cycle |
| reti_i | input | 1 | Return-from-interrupt strobe |
| retire_i | input | 1 | One main-program instruction retired |
| vec_sel_i | input | 1 | Select alternate vector base |
| irq_take_o | output | 1 | Interrupt taken this cycle |
| irq_vec_o | output | ADDR_W | Handler vector address, valid with irq_take_o |
| pend_o | output | N_SRC | Pending view (latched flags, or level inputs) |
| gie_o | output | 1 | Global enable state |

## Verification
A corrupted latched flag shows on pend_o one cycle after the edge or clear that caused it. It then appears as a take with the wrong vector as soon as both enables are set. A wrong global enable or post-return hold shows in the same cycle as a take that should have been held back, or as a missing take. Because the take path is combinational, each error is visible at the ports within one cycle of the state going wrong. A bench model that is compared every cycle therefore localises the fault to the edge where it happened.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned VEC_STRIDE  = 2;  // words per vector slot
  localparam int unsigned RESET_SLOTS = 1;  // slot 0 belongs to reset
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int unsigned     N_SRC      = 8,
  parameter logic [N_SRC-1:0] LATCH_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] clr_sw_i,
  input  logic [N_SRC-1:0] clr_hw_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] src_q, flag_q, flag_d, rise;

  assign rise   = src_i & ~src_q;
  // new edge wins over a clear in the same cycle
  assign flag_d = ((flag_q & ~(clr_sw_i | clr_hw_i)) | rise) & LATCH_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      flag_q <= '0;
    end else begin
      src_q  <= src_i;
      flag_q <= flag_d;
    end
  end

  for (genvar k = 0; k < N_SRC; k++) begin : g_pend
    if (LATCH_MASK[k]) begin : g_latch
      assign pend_o[k] = flag_q[k];
      AST_FLAG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q[k] && !clr_sw_i[k] && !clr_hw_i[k]) |=> flag_q[k]); // R5
      AST_FLAG_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_i[k] && !src_q[k]) |=> flag_q[k]); // R4
    end else begin : g_level
      assign pend_o[k] = src_i[k];
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [N_SRC-1:0] grant_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_SRC:0] below;

  assign below[0] = 1'b0;
  for (genvar k = 0; k < N_SRC; k++) begin : g_chain
    assign below[k+1]  = below[k] | req_i[k];
    assign grant_o[k]  = req_i[k] & ~below[k];
  end
  assign any_o = below[N_SRC];

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < N_SRC; k++)
      if (grant_o[k]) idx_o = idx_o | IDX_W'(k);
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic reti_i,
  input  logic retire_i,
  output logic gie_o,
  output logic hold_o
);
  logic gie_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (take_i || clr_i)       gie_q <= 1'b0;
      else if (reti_i || set_i)  gie_q <= 1'b1;
      if (reti_i)                hold_q <= 1'b1;
      else if (retire_i)         hold_q <= 1'b0;
    end
  end

  assign gie_o  = gie_q;
  assign hold_o = hold_q;

  AST_TAKE_CLEARS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !gie_o); // R3
  AST_RETI_SETS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !take_i && !clr_i) |=> gie_o); // R3
  AST_CLI_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !gie_o); // R8
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int unsigned      N_SRC      = 8,
  parameter int unsigned      ADDR_W     = 14,
  parameter logic [N_SRC-1:0] LATCH_MASK = 8'b0011_1101,
  parameter logic [ADDR_W-1:0] BASE_MAIN = 14'h0000,
  parameter logic [ADDR_W-1:0] BASE_ALT  = 14'h1C00,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [N_SRC-1:0]  src_en_i,
  input  logic [N_SRC-1:0]  flag_clr_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  input  logic              reti_i,
  input  logic              retire_i,
  input  logic              vec_sel_i,
  output logic              irq_take_o,
  output logic [ADDR_W-1:0] irq_vec_o,
  output logic [N_SRC-1:0]  pend_o,
  output logic              gie_o
);
  import irq_pkg::*;

  logic [N_SRC-1:0] pend, req, grant, clr_hw;
  logic             any_req, hold, take;
  logic [IDX_W-1:0] idx;
  logic [ADDR_W-1:0] base, slot_off;

  irq_flags #(.N_SRC(N_SRC), .LATCH_MASK(LATCH_MASK)) u_flags (
    .clk_i, .rst_ni, .src_i,
    .clr_sw_i (flag_clr_i),
    .clr_hw_i (clr_hw),
    .pend_o   (pend)
  );

  assign req = pend & src_en_i;

  irq_prio #(.N_SRC(N_SRC)) u_prio (
    .req_i (req), .any_o (any_req), .grant_o (grant), .idx_o (idx)
  );

  irq_gate u_gate (
    .clk_i, .rst_ni,
    .take_i   (take),
    .set_i    (gie_set_i),
    .clr_i    (gie_clr_i),
    .reti_i,
    .retire_i,
    .gie_o,
    .hold_o   (hold)
  );

  // disable and return both act in their own cycle
  assign take     = any_req & gie_o & ~gie_clr_i & ~hold & ~reti_i;
  assign clr_hw   = grant & {N_SRC{take}};
  assign base     = vec_sel_i ? BASE_ALT : BASE_MAIN;
  assign slot_off = ADDR_W'((32'(idx) + RESET_SLOTS) * VEC_STRIDE);

  assign irq_take_o = take;
  assign irq_vec_o  = base + slot_off;
  assign pend_o     = pend;

  AST_TAKE_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> gie_o); // R1
  AST_TAKE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (|(pend_o & src_en_i))); // R1
  AST_CLI_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_clr_i |-> !irq_take_o); // R8
  AST_HOLD_AFTER_RETI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !retire_i) |=> !irq_take_o); // R7
  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_hw)); // R2
endmodule

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
  localparam int N = 8;
  localparam int AW = 14;
  localparam logic [N-1:0]  LM   = 8'b0011_1101;
  localparam logic [AW-1:0] BMAIN = 14'h0000;
  localparam logic [AW-1:0] BALT  = 14'h1C00;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0, en = '0, clr = '0;
  logic sei = 0, cli = 0, reti = 0, retire = 0, vsel = 0;
  logic take;
  logic [AW-1:0] vec;
  logic [N-1:0] pend;
  logic gie;

  always #2 clk = ~clk;

  irq_vec_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .src_en_i(en), .flag_clr_i(clr),
    .gie_set_i(sei), .gie_clr_i(cli), .reti_i(reti), .retire_i(retire),
    .vec_sel_i(vsel), .irq_take_o(take), .irq_vec_o(vec), .pend_o(pend), .gie_o(gie)
  );

  // behavioural reference state
  logic [N-1:0] m_flag = '0, m_prev = '0;
  bit m_gie = 0, m_hold = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic step(input string tag);
    logic [N-1:0] e_pend, e_req;
    bit e_take;
    int e_idx;
    logic [AW-1:0] e_vec;
    #1;
    e_pend = (m_flag & LM) | (src & ~LM);
    e_req  = e_pend & en;
    e_idx  = -1;
    for (int k = N-1; k >= 0; k--) if (e_req[k]) e_idx = k;
    e_take = (e_idx >= 0) && m_gie && !cli && !m_hold && !reti;
    e_vec  = (vsel ? BALT : BMAIN) + AW'(2 * (e_idx + 1));
    checks++;
    if (take !== e_take || pend !== e_pend || gie !== m_gie ||
        (e_take && vec !== e_vec)) begin
      fails++;
      $display("FAIL %s t=%0t take=%b/%b pend=%h/%h gie=%b/%b vec=%h/%h (actual/expected)",
               tag, $time, take, e_take, pend, e_pend, gie, m_gie, vec, e_vec);
    end
    @(posedge clk);
    m_flag = ((m_flag & ~(clr | (e_take ? N'(1) << e_idx : '0))) | (src & ~m_prev)) & LM;
    m_prev = src;
    if (e_take || cli)      m_gie = 0;
    else if (reti || sei)   m_gie = 1;
    if (reti)               m_hold = 1;
    else if (retire)        m_hold = 0;
    @(negedge clk);
    clr = '0; sei = 0; cli = 0; reti = 0; retire = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2, "R11 reset state");

    // R6: level source 1 pulses while disabled, then enabled: nothing
    src[1] = 1; idle(2, "R6 level pulse");
    src[1] = 0; step("R6 level gone");
    en[1] = 1; sei = 1; step("R6 enable");
    idle(2, "R6 no take");

    // R5: latched source 2 edge while disabled, then enabled
    src[2] = 1; step("R5 edge"); src[2] = 0; idle(3, "R5 held");
    en[2] = 1; step("R5 taken, vec slot 3");
    idle(2, "R3 gie cleared after take");
    reti = 1; step("R3 reti"); retire = 1; step("R7 retire");

    // R4: software clear, and edge vs clear in same cycle
    src[3] = 1; step("R4 edge"); src[3] = 0;
    clr[3] = 1; step("R4 sw clear"); idle(1, "R4 cleared");
    src[3] = 1; clr[3] = 1; step("R4 edge beats clear"); src[3] = 0;
    idle(1, "R4 still set"); clr[3] = 1; step("R4 clear again");

    // R2: priority between sources 0 and 4
    cli = 1; step("R8 cli");
    src[0] = 1; src[4] = 1; step("R2 edges"); src[0] = 0; src[4] = 0;
    en[0] = 1; en[4] = 1; sei = 1; step("R2 gie on");
    step("R2 source 0 wins");
    reti = 1; step("R7 reti");
    idle(3, "R7 held without retire");
    retire = 1; step("R7 retire");
    step("R2 source 4 next");

    // R8: cli in the cycle of a pending request with gie set
    src[5] = 1; en[5] = 1; step("R8 edge"); src[5] = 0;
    reti = 1; retire = 1; step("R8 reti"); step("R8 hold");
    retire = 1; cli = 1; sei = 1; step("R8 cli blocks, beats sei");
    idle(1, "R8 gie off");

    // R9: alternate base
    vsel = 1; sei = 1; step("R9 set"); step("R9 alt vec");
    vsel = 0;

    // R10: nesting inside a handler
    src[6] = 1; en[6] = 1; step("R10 level 6 pending");
    sei = 1; step("R10 sei in handler"); step("R10 nested take");
    src[6] = 0; step("R10 done");

    // R1 + R2: random traffic
    for (int i = 0; i < 3000; i++) begin
      src = N'($urandom); en = N'($urandom);
      clr = N'($urandom) & N'($urandom) & N'($urandom);
      sei = ($urandom % 4) == 0; cli = ($urandom % 9) == 0;
      reti = ($urandom % 7) == 0; retire = ($urandom % 3) == 0;
      vsel = ($urandom % 5) == 0;
      step("R1 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule